// File: doc/BRIEF.md
# Manager Bus Command Sequencer

This block is the master side of an 8-bit command/status/data bus to a switch controller. A local requester starts a transaction with one pulse. With that pulse it supplies a command byte, a count of data bytes to write, a count of data bytes to read back, up to thirteen write bytes and a poll limit. The sequencer then runs the whole exchange without further help.

The exchange has four steps, always in this order:
1. It loads the data registers.
2. It writes the command register.
3. It reads the status register again and again until bit 7 comes back high.
4. It fetches the requested data registers.

When the exchange ends, the sequencer raises a one-cycle completion pulse and presents the fetched bytes.

Every bus access has three phases: a setup cycle, a strobe-low window, and a hold cycle. For a write, the master drives the byte across the whole access, so the byte is stable across the rising strobe edge. For a read, the master releases the bus and samples it at the end of the strobe-low window. The controller may take a very long time to acknowledge under heavy traffic. A programmable poll limit therefore lets the requester end a stuck transaction with an error indication.

Top module: `mgr_bus_seq`

## Requirements
- R1: A transaction performs its accesses in this order:
  - data writes (select high) in index order 0, 1, 2 …;
  - exactly one command write (select low);
  - status reads (select low);
  - data reads (select high) in index order.
- R2: The read/write line is 1 during every read access and 0 during every write access. The select line is 0 for command/status accesses and 1 for data accesses. Both lines stay unchanged from setup through hold of an access.
- R3: During a write access the master drives the byte from before the strobe falls until after it rises, and the byte does not change across the rising edge. The master drives the bus only during write accesses.
- R4: Read data is sampled while the strobe is low. The byte fetched from data register i appears in bits [8*i+7:8*i] of `rsp_rdata`.
- R5: A status read whose bit 7 is 1 is the acknowledge; status reads with bit 7 at 0 are followed by another status read. No second command write occurs before the transaction ends.
- R6: The write count and the read count are independent. Either may be zero, in which case no access of that kind takes place.
- R7: A write count or read count above 13 is treated as 13.
- R8: If `poll_limit` is nonzero and that many status reads return bit 7 at 0, the transaction ends:
  - `done` is raised with `err` at 1;
  - no data reads take place.
  A `poll_limit` of 0 polls without limit. `err` is 0 on every other completion.
- R9: `done` is a one-cycle pulse. `busy` is 1 from the cycle after `req_start` through the `done` cycle, and 0 in the cycle after it. Bytes of `rsp_rdata` at indices not read in the transaction are zero, and the value holds until the next start.
- R10: `req_start` while `busy` is 1 is ignored, along with the request inputs presented with it.
- R11: After reset the strobe is high, the read/write line is 1, and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse for a transaction |
| req_cmd | input | 8 | Command byte |
| req_wr_cnt | input | 4 | Number of data bytes to write (clamped to 13) |
| req_rd_cnt | input | 4 | Number of data bytes to read (clamped to 13) |
| req_wdata | input | 104 | Write bytes, byte i in bits [8i+7:8i] |
| poll_limit | input | 16 | Maximum non-acknowledged status reads, 0 = unlimited |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached, valid with done |
| rsp_rdata | output | 104 | Fetched bytes, byte i in bits [8i+7:8i] |
| mb_rw | output | 1 | 1 = read access, 0 = write access |
| mb_dsel | output | 1 | 0 = command/status register, 1 = data registers |
| mb_strb_n | output | 1 | Active-low strobe |
| mb_data | inout | 8 | Bidirectional data bus |

## Verification
The assertions rely on the controller driving the bus only while the strobe is low with the read/write line high. They also rely on the requester treating `done` as the only end of a transaction. The bench target model obeys the first of these: it drives the bus only in that window. Its status byte raises bit 7 only after a chosen number of non-acknowledged reads. Random requests draw counts from 0 to 15 and acknowledge delays on either side of the poll limit. Start pulses are issued while idle, apart from one directed case that deliberately pulses start mid-transaction.

// File: rtl/mgr_bus_pkg.sv
package mgr_bus_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_CMD,
      SQ_POLL,
      SQ_FETCH,
      SQ_DONE
   } seq_st_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_LOW,
      PH_HOLD
   } ph_t;

   localparam int unsigned ACK_BIT = 7;
endpackage

// File: rtl/mgr_bus_cycle.sv
module mgr_bus_cycle
   import mgr_bus_pkg::*;
#(
   parameter int DW      = 8,
   parameter int LOW_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_rd,
   input  logic          go_dsel,
   input  logic [DW-1:0] go_wdata,
   input  logic [DW-1:0] bus_din,
   output logic          idle,
   output logic          fin,
   output logic [DW-1:0] rdata,
   output logic          rw,
   output logic          dsel,
   output logic          strb_n,
   output logic          oe,
   output logic [DW-1:0] dout
);
   ph_t           ph_q;
   logic          rd_q;
   logic          dsel_q;
   logic [DW-1:0] wd_q;
   logic [DW-1:0] rdata_q;
   logic          last_low;

   generate
      if (LOW_CYC == 1) begin : g_single
         assign last_low = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(LOW_CYC);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (ph_q != PH_LOW) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign last_low = (cnt_q == CW'(LOW_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         rd_q    <= 1'b1;
         dsel_q  <= 1'b0;
         wd_q    <= '0;
         rdata_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (go) begin
               ph_q   <= PH_SETUP;
               rd_q   <= go_rd;
               dsel_q <= go_dsel;
               wd_q   <= go_wdata;
            end
            PH_SETUP: ph_q <= PH_LOW;
            PH_LOW: if (last_low) begin
               ph_q <= PH_HOLD;
               if (rd_q) rdata_q <= bus_din;
            end
            PH_HOLD: ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign idle   = (ph_q == PH_IDLE);
   assign fin    = (ph_q == PH_HOLD);
   assign rdata  = rdata_q;
   assign rw     = idle ? 1'b1 : rd_q;
   assign dsel   = idle ? 1'b0 : dsel_q;
   assign strb_n = (ph_q != PH_LOW);
   assign oe     = !idle && !rd_q;
   assign dout   = wd_q;
endmodule

// File: rtl/mgr_bus_regbank.sv
module mgr_bus_regbank #(
   parameter int DW   = 8,
   parameter int NREG = 13,
   parameter int IW   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NREG*DW-1:0] load_data,
   input  logic [IW-1:0]      sel_idx,
   output logic [DW-1:0]      sel_byte,
   input  logic               cap_en,
   input  logic [IW-1:0]      cap_idx,
   input  logic [DW-1:0]      cap_data,
   output logic [NREG*DW-1:0] rd_flat
);
   logic [DW-1:0] wr_arr [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] wr_q;
      logic [DW-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
         end else if (load) begin
            wr_q <= load_data[g*DW +: DW];
            rd_q <= '0;
         end else if (cap_en && (cap_idx == IW'(g))) begin
            rd_q <= cap_data;
         end
      end
      assign wr_arr[g]            = wr_q;
      assign rd_flat[g*DW +: DW]  = rd_q;
   end

   always_comb begin
      sel_byte = '0;
      for (int k = 0; k < NREG; k++) begin
         if (sel_idx == IW'(k)) sel_byte = wr_arr[k];
      end
   end
endmodule

// File: rtl/mgr_bus_seq_fsm.sv
module mgr_bus_seq_fsm
   import mgr_bus_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NREG = 13,
   parameter int IW   = 4,
   parameter int PLW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [IW-1:0]  wr_cnt,
   input  logic [IW-1:0]  rd_cnt,
   input  logic [PLW-1:0] limit,
   input  logic           cyc_idle,
   input  logic           cyc_fin,
   input  logic [DW-1:0]  cyc_rdata,
   output logic           go,
   output logic           go_rd,
   output logic           go_dsel,
   output logic           send_cmd,
   output logic [IW-1:0]  idx,
   output logic           cap_en,
   output logic           load,
   output logic           busy,
   output logic           done,
   output logic           err
);
   localparam logic [IW-1:0] NMAX = IW'(NREG);

   seq_st_t        st_q;
   logic [IW-1:0]  idx_q;
   logic [IW-1:0]  wn_q;
   logic [IW-1:0]  rn_q;
   logic [PLW-1:0] lim_q;
   logic [PLW-1:0] pcnt_q;
   logic           err_q;
   logic [IW-1:0]  wn_c;
   logic [IW-1:0]  rn_c;
   logic           acked;
   logic           give_up;

   assign wn_c    = (wr_cnt > NMAX) ? NMAX : wr_cnt;
   assign rn_c    = (rd_cnt > NMAX) ? NMAX : rd_cnt;
   assign acked   = cyc_rdata[ACK_BIT];
   assign give_up = (lim_q != '0) && ((pcnt_q + 1'b1) == lim_q);
   assign load    = (st_q == SQ_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         wn_q   <= '0;
         rn_q   <= '0;
         lim_q  <= '0;
         pcnt_q <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (start) begin
               wn_q   <= wn_c;
               rn_q   <= rn_c;
               lim_q  <= limit;
               idx_q  <= '0;
               pcnt_q <= '0;
               err_q  <= 1'b0;
               st_q   <= (wn_c == '0) ? SQ_CMD : SQ_LOAD;
            end
            SQ_LOAD: if (cyc_fin) begin
               if (idx_q == wn_q - 1'b1) begin
                  idx_q <= '0;
                  st_q  <= SQ_CMD;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            SQ_CMD: if (cyc_fin) begin
               pcnt_q <= '0;
               st_q   <= SQ_POLL;
            end
            SQ_POLL: if (cyc_fin) begin
               if (acked) begin
                  idx_q <= '0;
                  st_q  <= (rn_q == '0) ? SQ_DONE : SQ_FETCH;
               end else if (give_up) begin
                  err_q <= 1'b1;
                  st_q  <= SQ_DONE;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            SQ_FETCH: if (cyc_fin) begin
               if (idx_q == rn_q - 1'b1) st_q  <= SQ_DONE;
               else                      idx_q <= idx_q + 1'b1;
            end
            SQ_DONE: st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      go       = 1'b0;
      go_rd    = 1'b1;
      go_dsel  = 1'b0;
      send_cmd = 1'b0;
      unique case (st_q)
         SQ_LOAD:  begin go = cyc_idle; go_rd = 1'b0; go_dsel = 1'b1; end
         SQ_CMD:   begin go = cyc_idle; go_rd = 1'b0; send_cmd = 1'b1; end
         SQ_POLL:  begin go = cyc_idle; end
         SQ_FETCH: begin go = cyc_idle; go_dsel = 1'b1; end
         default:  ;
      endcase
   end

   assign idx    = idx_q;
   assign cap_en = cyc_fin && (st_q == SQ_FETCH);
   assign busy   = (st_q != SQ_IDLE);
   assign done   = (st_q == SQ_DONE);
   assign err    = done && err_q;
endmodule

// File: rtl/mgr_bus_seq.sv
module mgr_bus_seq #(
   parameter int DW      = 8,
   parameter int NREG    = 13,
   parameter int PLW     = 16,
   parameter int LOW_CYC = 2,
   localparam int IW     = $clog2(NREG + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_start,
   input  logic [DW-1:0]      req_cmd,
   input  logic [IW-1:0]      req_wr_cnt,
   input  logic [IW-1:0]      req_rd_cnt,
   input  logic [NREG*DW-1:0] req_wdata,
   input  logic [PLW-1:0]     poll_limit,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [NREG*DW-1:0] rsp_rdata,
   output logic               mb_rw,
   output logic               mb_dsel,
   output logic               mb_strb_n,
   inout  wire  [DW-1:0]      mb_data
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("mgr_bus_seq: DW must be at least 8 for the acknowledge bit");
      end
      if (NREG < 1) begin : g_bad_nreg
         $error("mgr_bus_seq: NREG must be at least 1");
      end
      if (LOW_CYC < 1) begin : g_bad_low
         $error("mgr_bus_seq: LOW_CYC must be at least 1");
      end
   endgenerate

   logic          go, go_rd, go_dsel, send_cmd;
   logic          cyc_idle, cyc_fin, cap_en, load;
   logic [IW-1:0] idx;
   logic [DW-1:0] cyc_rdata, data_byte, drv_byte;
   logic [DW-1:0] cmd_q;
   logic          drv_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmd_q <= '0;
      else if (load) cmd_q <= req_cmd;
   end

   mgr_bus_seq_fsm #(.DW(DW), .NREG(NREG), .IW(IW), .PLW(PLW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(req_start),
      .wr_cnt(req_wr_cnt), .rd_cnt(req_rd_cnt), .limit(poll_limit),
      .cyc_idle(cyc_idle), .cyc_fin(cyc_fin), .cyc_rdata(cyc_rdata),
      .go(go), .go_rd(go_rd), .go_dsel(go_dsel), .send_cmd(send_cmd),
      .idx(idx), .cap_en(cap_en), .load(load),
      .busy(busy), .done(done), .err(err)
   );

   mgr_bus_regbank #(.DW(DW), .NREG(NREG), .IW(IW)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(load), .load_data(req_wdata),
      .sel_idx(idx), .sel_byte(data_byte),
      .cap_en(cap_en), .cap_idx(idx), .cap_data(cyc_rdata),
      .rd_flat(rsp_rdata)
   );

   mgr_bus_cycle #(.DW(DW), .LOW_CYC(LOW_CYC)) u_cyc (
      .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_dsel(go_dsel),
      .go_wdata(send_cmd ? cmd_q : data_byte), .bus_din(mb_data),
      .idle(cyc_idle), .fin(cyc_fin), .rdata(cyc_rdata),
      .rw(mb_rw), .dsel(mb_dsel), .strb_n(mb_strb_n),
      .oe(drv_en), .dout(drv_byte)
   );

   assign mb_data = drv_en ? drv_byte : {DW{1'bz}};
endmodule

// File: rtl/mgr_bus_seq_chk.sv
module mgr_bus_seq_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          rw,
   input logic          dsel,
   input logic          strb_n,
   input logic          oe,
   input logic [DW-1:0] dout
);
   logic cmd_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cmd_pending <= 1'b0;
      else if (done)                   cmd_pending <= 1'b0;
      else if (strb_n && !$past(strb_n) && !rw && !dsel) cmd_pending <= 1'b1;
   end

   a_r3_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) && !rw |-> oe && $stable(dout));

   a_r3_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !rw);

   a_r2_lines_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_n && $past(!strb_n) |-> $stable(rw) && $stable(dsel));

   a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) && !rw && !dsel |-> !cmd_pending);

   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_n |-> busy);
endmodule

bind mgr_bus_seq mgr_bus_seq_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .rw(mb_rw), .dsel(mb_dsel), .strb_n(mb_strb_n),
   .oe(drv_en), .dout(drv_byte)
);

// File: tb/tb_mgr_bus_seq.sv
`timescale 1ns/1ps
module tb_mgr_bus_seq;
   localparam int NREG = 13;
   localparam int DW   = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_start = 1'b0;
   logic [7:0]         req_cmd = '0;
   logic [3:0]         req_wr_cnt = '0;
   logic [3:0]         req_rd_cnt = '0;
   logic [NREG*DW-1:0] req_wdata = '0;
   logic [15:0]        poll_limit = '0;
   logic               busy, done, err, mb_rw, mb_dsel, mb_strb_n;
   logic [NREG*DW-1:0] rsp_rdata;
   wire  [7:0]         mb_data;

   always #2.5 clk = ~clk;

   mgr_bus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
      .req_wr_cnt(req_wr_cnt), .req_rd_cnt(req_rd_cnt), .req_wdata(req_wdata),
      .poll_limit(poll_limit), .busy(busy), .done(done), .err(err),
      .rsp_rdata(rsp_rdata), .mb_rw(mb_rw), .mb_dsel(mb_dsel),
      .mb_strb_n(mb_strb_n), .mb_data(mb_data)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Target model
   logic       log_en = 1'b0;
   logic [7:0] tgt_cmd = '0;
   int         ack_after = 0;
   int         stat_reads = 0;
   int         data_reads = 0;
   int         wcount = 0;
   bit         cmd_seen = 0;
   bit         acked = 0;
   bit         order_bad = 0;
   logic [7:0] wlog_val [64];
   bit         wlog_sel [64];

   function automatic logic [7:0] tgt_rbyte(logic [7:0] c, int i);
      return c ^ 8'(i * 29) ^ 8'hA5;
   endfunction

   logic [7:0] tgt_byte;
   always_comb tgt_byte = mb_dsel ? tgt_rbyte(tgt_cmd, data_reads)
                                  : {(stat_reads >= ack_after), 7'h15};
   assign mb_data = (!mb_strb_n && mb_rw) ? tgt_byte : 8'hzz;

   always @(posedge mb_strb_n) begin
      if (log_en) begin
         if (!mb_rw) begin
            if (cmd_seen) order_bad = 1;
            if (!mb_dsel) cmd_seen = 1;
            if (wcount < 64) begin
               wlog_val[wcount] = mb_data;
               wlog_sel[wcount] = mb_dsel;
            end
            wcount++;
         end else if (!mb_dsel) begin
            if (!cmd_seen || acked) order_bad = 1;
            if (stat_reads >= ack_after) acked = 1;
            stat_reads++;
         end else begin
            if (!acked) order_bad = 1;
            data_reads++;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int clampn(int v);
      return (v > NREG) ? NREG : v;
   endfunction

   task automatic run_txn(logic [7:0] cmd, int wr, int rd, int k, int lim, bit poke);
      int w, r, exp_polls, exp_reads;
      bit exp_err;
      logic [NREG*DW-1:0] wd;
      w = clampn(wr);
      r = clampn(rd);
      exp_err   = (lim != 0) && (k >= lim);
      exp_polls = exp_err ? lim : k + 1;
      exp_reads = exp_err ? 0 : r;
      for (int i = 0; i < NREG; i++) wd[i*8 +: 8] = 8'($urandom());
      @(negedge clk);
      tgt_cmd = cmd; ack_after = k; stat_reads = 0; data_reads = 0;
      wcount = 0; cmd_seen = 0; acked = 0; order_bad = 0;
      req_cmd = cmd; req_wr_cnt = 4'(wr); req_rd_cnt = 4'(rd);
      req_wdata = wd; poll_limit = 16'(lim); req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      chk(busy === 1'b1, "R9", "busy after start", busy, 1);
      if (poke) begin
         // R10: a start while busy must not alter the transaction
         repeat (3) @(negedge clk);
         req_cmd = ~cmd; req_wr_cnt = 4'd0; req_rd_cnt = 4'd0;
         poll_limit = 16'd1; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
      end
      for (int t = 0; t < 20000; t++) begin
         if (done === 1'b1) break;
         @(negedge clk);
      end
      chk(done === 1'b1, "R9", "done seen", done, 1);
      chk(err === exp_err, "R8", "err flag", err, exp_err);
      chk(!order_bad, "R1", "access order", order_bad, 0);
      chk(wcount == w + 1, "R5", "write count", wcount, w + 1);
      for (int i = 0; i < w && i < 64; i++) begin
         chk(wlog_sel[i] == 1 && wlog_val[i] == wd[i*8 +: 8], "R1",
             $sformatf("data write %0d", i), wlog_val[i], wd[i*8 +: 8]);
      end
      if (w < 64) chk(wlog_sel[w] == 0 && wlog_val[w] == cmd, "R2",
                      "command write", wlog_val[w], cmd);
      chk(stat_reads == exp_polls, "R8", "status reads", stat_reads, exp_polls);
      chk(data_reads == exp_reads, "R6", "data reads", data_reads, exp_reads);
      for (int i = 0; i < NREG; i++) begin
         logic [7:0] eb;
         eb = (i < exp_reads) ? tgt_rbyte(cmd, i) : 8'h00;
         chk(rsp_rdata[i*8 +: 8] == eb, "R4", $sformatf("read byte %0d", i),
             rsp_rdata[i*8 +: 8], eb);
      end
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R9", "idle after done", {done, busy}, 0);
      chk(mb_strb_n === 1'b1, "R11", "strobe idle high", mb_strb_n, 1);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(mb_strb_n === 1'b1 && mb_rw === 1'b1, "R11", "bus lines in reset",
          {mb_strb_n, mb_rw}, 2'b11);
      chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11", "status in reset",
          {busy, done, err}, 0);
      rst_n = 1'b1;
      log_en = 1'b1;
      @(negedge clk);
      // directed corners
      run_txn(8'h3C, 0, 0, 0, 4, 0);    // R6 both counts zero
      run_txn(8'h81, 13, 13, 2, 0, 0);  // full counts, unlimited poll
      run_txn(8'h42, 15, 14, 1, 8, 0);  // R7 clamp to 13
      run_txn(8'h17, 3, 5, 6, 6, 0);    // R8 limit reached exactly
      run_txn(8'h55, 2, 4, 5, 6, 0);    // ack on last allowed poll
      run_txn(8'h99, 0, 7, 25, 0, 0);   // R8 limit 0 polls on
      run_txn(8'hE0, 4, 3, 3, 0, 1);    // R10 start while busy
      for (int n = 0; n < 40; n++) begin
         run_txn(8'($urandom()), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 12)),
                 int'($urandom_range(0, 10)), 0);
      end
      finish_run();
   end
endmodule